// File: doc/BRIEF.md
# Precise Exception Sequencer

This block sequences exceptions for a five-stage in-order pipeline. Three stages (decode, execute, memory) each report whether they hold a live instruction, whether that instruction asks for an exception, a 4-bit cause code and the instruction's own PC. In the cycle a request is accepted, the sequencer picks the request from the oldest instruction. It kills that instruction and every younger one, and lets older ones drain. It also cancels a data-memory write from the memory stage when the memory stage itself is the one that faults.

On the clock edge that ends the accepting cycle, the faulting instruction's PC and its cause code are latched. The next cycle is a one-cycle redirect. In that cycle fetch is steered to the handler. In vectored mode the target is the base address plus the cause times sixteen. Otherwise the target is the base address alone.

The controller has two named states. `ST_RUN` watches requests. Its transition `accept` fires when any live request is present and moves to `ST_REDIRECT`. In that state the target is presented and requests are ignored. The transition `resume` always returns to `ST_RUN` after one cycle.

Top module: `exc_seq_ctrl`

## Requirements
- R1: After reset, saved PC and saved cause are zero, no flush bit is set, `redirect` is low and the controller is in `ST_RUN`.
- R2: A request from a stage whose valid flag is low is ignored. With no live request, `exc_taken` is low and `flush` is zero.
- R3: When several live requests occur in one cycle, the memory stage wins over execute, and execute wins over decode.
- R4: `flush` bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory. In an accepting cycle, fetch and every stage from decode up to and including the winning stage are set, and stages older than the winner are clear. A memory winner gives 4'b1111, execute gives 4'b0111 and decode gives 4'b0011.
- R5: `mem_store_en` equals `mem_store_req` AND `mem_valid`, except that it is forced low in a cycle where the memory stage's own exception is accepted.
- R6: On the edge after acceptance, `epc` takes the winning stage's PC and `cause` takes the winning stage's cause code.
- R7: `epc` and `cause` keep their values in every cycle in which no exception is accepted.
- R8: `redirect` is high for exactly the one cycle after acceptance. In that cycle `redirect_pc` is `handler_base + (cause << 4)` when `vector_mode` is 1, and `handler_base` when it is 0.
- R9: During the redirect cycle all requests are ignored: `exc_taken` is low, `flush` is zero and `epc`/`cause` hold.
- R10: `exc_taken` rises combinationally in the same cycle as the live request that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vector_mode | input | 1 | 1 selects a cause-indexed handler target |
| handler_base | input | PC_W | Handler base address |
| dec_valid | input | 1 | Decode stage holds a live instruction |
| dec_req | input | 1 | Decode instruction requests an exception |
| dec_cause | input | CAUSE_W | Decode cause code |
| dec_pc | input | PC_W | Decode instruction PC |
| exe_valid | input | 1 | Execute stage holds a live instruction |
| exe_req | input | 1 | Execute instruction requests an exception |
| exe_cause | input | CAUSE_W | Execute cause code |
| exe_pc | input | PC_W | Execute instruction PC |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_req | input | 1 | Memory instruction requests an exception |
| mem_cause | input | CAUSE_W | Memory cause code |
| mem_pc | input | PC_W | Memory instruction PC |
| mem_store_req | input | 1 | Memory stage wants to write data memory |
| mem_store_en | output | 1 | Qualified data-memory write enable |
| exc_taken | output | 1 | An exception is accepted this cycle |
| flush | output | 4 | Per-stage kill: fetch, decode, execute, memory |
| redirect | output | 1 | Fetch must load `redirect_pc` this cycle |
| redirect_pc | output | PC_W | Handler target address |
| epc | output | PC_W | Saved PC of the faulting instruction |
| cause | output | CAUSE_W | Saved cause code |

## Verification
The bench walks every combination of valid and request flags over the three stages, in both handler modes. This separates masking by the valid flag from age priority, and it shows whether each winner produces the correct flush depth, store gate, saved PC and cause. Each stage carries a distinct PC and cause that also differ from sweep step to sweep step, so a selection taken from the wrong stage shows up in the saved values. Live requests are also driven on every stage during each redirect cycle, to confirm that the second state ignores them and that the saved registers hold.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NUM_EXC_STAGES = 3;   // decode, execute, memory
    localparam int FLUSH_W        = NUM_EXC_STAGES + 1;

    typedef enum logic [0:0] {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/exc_age_arbiter.sv
// Picks the live request from the oldest stage; higher index is older.
module exc_age_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] live_req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] older_busy;

    assign older_busy[N] = 1'b0;

    for (genvar i = N - 1; i >= 0; i--) begin : g_age
        assign grant[i]      = live_req[i] & ~older_busy[i+1];
        assign older_busy[i] = older_busy[i+1] | live_req[i];
    end

    assign any = older_busy[0];
endmodule

// File: rtl/exc_kill_decode.sv
// Turns a one-hot winner into a kill mask: fetch plus the winner and all younger stages.
module exc_kill_decode #(
    parameter int N = 3
) (
    input  logic         enable,
    input  logic [N-1:0] grant,
    output logic [N:0]   kill
);
    logic [N:0] at_or_deeper;

    assign at_or_deeper[N] = 1'b0;

    for (genvar i = N - 1; i >= 0; i--) begin : g_kill
        assign at_or_deeper[i] = at_or_deeper[i+1] | grant[i];
        assign kill[i+1]       = enable & at_or_deeper[i];
    end

    assign kill[0] = enable & at_or_deeper[0];
endmodule

// File: rtl/exc_target_calc.sv
// Handler target: base, or base plus cause scaled by the vector spacing.
module exc_target_calc #(
    parameter int PC_W      = 32,
    parameter int CAUSE_W   = 4,
    parameter int VEC_SHIFT = 4
) (
    input  logic               vector_mode,
    input  logic [PC_W-1:0]    base,
    input  logic [CAUSE_W-1:0] cause_code,
    output logic [PC_W-1:0]    target
);
    localparam int PAD_W = PC_W - CAUSE_W;

    logic [PC_W-1:0] offset;

    assign offset = {{PAD_W{1'b0}}, cause_code} << VEC_SHIFT;
    assign target = vector_mode ? (base + offset) : base;
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int CAUSE_W   = 4,
    parameter int VEC_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vector_mode,
    input  logic [PC_W-1:0]    handler_base,
    input  logic               dec_valid,
    input  logic               dec_req,
    input  logic [CAUSE_W-1:0] dec_cause,
    input  logic [PC_W-1:0]    dec_pc,
    input  logic               exe_valid,
    input  logic               exe_req,
    input  logic [CAUSE_W-1:0] exe_cause,
    input  logic [PC_W-1:0]    exe_pc,
    input  logic               mem_valid,
    input  logic               mem_req,
    input  logic [CAUSE_W-1:0] mem_cause,
    input  logic [PC_W-1:0]    mem_pc,
    input  logic               mem_store_req,
    output logic               mem_store_en,
    output logic               exc_taken,
    output logic [3:0]         flush,
    output logic               redirect,
    output logic [PC_W-1:0]    redirect_pc,
    output logic [PC_W-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    localparam int N     = NUM_EXC_STAGES;
    localparam int MEM_I = N - 1;

    seq_state_e state_q, state_d;

    logic [N-1:0]       stg_valid, stg_req, live_req, grant;
    logic [CAUSE_W-1:0] stg_cause [N];
    logic [PC_W-1:0]    stg_pc    [N];
    logic               any_live;
    logic               accept;
    logic [PC_W-1:0]    win_pc;
    logic [CAUSE_W-1:0] win_cause;
    logic [N:0]         kill;

    // Stage order: index 0 youngest (decode) .. index N-1 oldest (memory)
    assign stg_valid    = {mem_valid, exe_valid, dec_valid};
    assign stg_req      = {mem_req, exe_req, dec_req};
    assign stg_cause[0] = dec_cause;
    assign stg_cause[1] = exe_cause;
    assign stg_cause[2] = mem_cause;
    assign stg_pc[0]    = dec_pc;
    assign stg_pc[1]    = exe_pc;
    assign stg_pc[2]    = mem_pc;

    assign live_req = stg_valid & stg_req;

    exc_age_arbiter #(.N(N)) u_arb (
        .live_req (live_req),
        .grant    (grant),
        .any      (any_live)
    );

    // One-hot mux of the winner's PC and cause
    always_comb begin
        win_pc    = '0;
        win_cause = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                win_pc    = win_pc | stg_pc[i];
                win_cause = win_cause | stg_cause[i];
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-state outputs
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        redirect = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (any_live) begin
                    accept  = 1'b1;           // transition: accept
                    state_d = ST_REDIRECT;
                end
            end
            ST_REDIRECT: begin
                redirect = 1'b1;
                state_d  = ST_RUN;            // transition: resume
            end
            default: state_d = ST_RUN;
        endcase
    end

    exc_kill_decode #(.N(N)) u_kill (
        .enable (accept),
        .grant  (grant),
        .kill   (kill)
    );

    assign exc_taken    = accept;
    assign flush        = kill;
    assign mem_store_en = mem_valid & mem_store_req & ~(accept & grant[MEM_I]);

    // Saved PC and cause load only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else if (accept) begin
            epc   <= win_pc;
            cause <= win_cause;
        end
    end

    exc_target_calc #(
        .PC_W      (PC_W),
        .CAUSE_W   (CAUSE_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_tgt (
        .vector_mode (vector_mode),
        .base        (handler_base),
        .cause_code  (cause),
        .target      (redirect_pc)
    );
endmodule

// File: rtl/exc_seq_checker.sv
module exc_seq_checker #(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dec_valid,
    input logic               exe_valid,
    input logic               mem_valid,
    input logic               mem_req,
    input logic [PC_W-1:0]    mem_pc,
    input logic               mem_store_en,
    input logic               exc_taken,
    input logic [3:0]         flush,
    input logic               redirect,
    input logic [PC_W-1:0]    epc,
    input logic [CAUSE_W-1:0] cause
);
    assert_invalid_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !exe_valid && !mem_valid) |-> (!exc_taken && flush == 4'b0000));

    assert_mem_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_req && !redirect) |=> (epc == $past(mem_pc)));

    assert_kill_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (flush[0] && flush[1]));

    assert_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && flush[3]) |-> !mem_store_en);

    assert_hold_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken |=> ($stable(epc) && $stable(cause)));

    assert_redirect_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> redirect);

    assert_redirect_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    assert_quiet_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (!exc_taken && flush == 4'b0000));
endmodule

bind exc_seq_ctrl exc_seq_checker #(
    .PC_W    (PC_W),
    .CAUSE_W (CAUSE_W)
) u_exc_seq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .exe_valid    (exe_valid),
    .mem_valid    (mem_valid),
    .mem_req      (mem_req),
    .mem_pc       (mem_pc),
    .mem_store_en (mem_store_en),
    .exc_taken    (exc_taken),
    .flush        (flush),
    .redirect     (redirect),
    .epc          (epc),
    .cause        (cause)
);

// File: tb/test_exc_seq_ctrl.sv
module test_exc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int CW         = 4;
    localparam logic [PC_W-1:0] BASE = 32'h8000_0100;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            vector_mode;
    logic [PC_W-1:0] handler_base;
    logic            dec_valid, dec_req, exe_valid, exe_req, mem_valid, mem_req;
    logic [CW-1:0]   dec_cause, exe_cause, mem_cause;
    logic [PC_W-1:0] dec_pc, exe_pc, mem_pc;
    logic            mem_store_req;
    logic            mem_store_en, exc_taken, redirect;
    logic [3:0]      flush;
    logic [PC_W-1:0] redirect_pc, epc;
    logic [CW-1:0]   cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_seq_ctrl #(.PC_W(PC_W), .CAUSE_W(CW), .VEC_SHIFT(4)) i_exc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .vector_mode(vector_mode), .handler_base(handler_base),
        .dec_valid(dec_valid), .dec_req(dec_req), .dec_cause(dec_cause), .dec_pc(dec_pc),
        .exe_valid(exe_valid), .exe_req(exe_req), .exe_cause(exe_cause), .exe_pc(exe_pc),
        .mem_valid(mem_valid), .mem_req(mem_req), .mem_cause(mem_cause), .mem_pc(mem_pc),
        .mem_store_req(mem_store_req), .mem_store_en(mem_store_en), .exc_taken(exc_taken),
        .flush(flush), .redirect(redirect), .redirect_pc(redirect_pc), .epc(epc), .cause(cause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {dec_valid, dec_req, exe_valid, exe_req, mem_valid, mem_req} = '0;
        mem_store_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [PC_W-1:0] saved_pc;
        logic [CW-1:0]   saved_cause;
        rst_n = 1'b0;
        vector_mode = 1'b0;
        handler_base = BASE;
        dec_cause = '0; exe_cause = '0; mem_cause = '0;
        dec_pc = '0; exe_pc = '0; mem_pc = '0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 epc", epc, 0);
        check("R1 cause", {28'd0, cause}, 0);
        check("R1 flush", {28'd0, flush}, 0);
        check("R1 redirect", {31'd0, redirect}, 0);
        saved_pc = '0;
        saved_cause = '0;

        for (int vm = 0; vm < 2; vm++) begin
            for (int pat = 0; pat < 64; pat++) begin
                logic [2:0] v, r, live;
                int win, step;
                logic [3:0] exp_flush;
                logic [CW-1:0] wc;
                logic [PC_W-1:0] wp, exp_tgt;
                step = vm * 64 + pat;
                v = pat[2:0];
                r = pat[5:3];
                live = v & r;
                @(negedge clk);
                vector_mode  = vm[0];
                dec_valid = v[0]; exe_valid = v[1]; mem_valid = v[2];
                dec_req   = r[0]; exe_req   = r[1]; mem_req   = r[2];
                dec_cause = CW'(step);
                exe_cause = CW'(step + 5);
                mem_cause = CW'(step + 11);
                dec_pc = 32'h0001_0000 + 32'(step) * 16 + 32'h4;
                exe_pc = 32'h0002_0000 + 32'(step) * 16 + 32'h8;
                mem_pc = 32'h0003_0000 + 32'(step) * 16 + 32'hC;
                mem_store_req = 1'b1;
                win = live[2] ? 2 : live[1] ? 1 : live[0] ? 0 : -1;
                exp_flush = (win < 0) ? 4'b0000 : 4'((1 << (win + 2)) - 1);
                wc = (win == 2) ? mem_cause : (win == 1) ? exe_cause : dec_cause;
                wp = (win == 2) ? mem_pc : (win == 1) ? exe_pc : dec_pc;
                #1;
                // R10 / R2: same-cycle acceptance only for live requests
                check(win < 0 ? "R2 taken" : "R10 taken", {31'd0, exc_taken}, {31'd0, win >= 0});
                // R4 / R3: flush depth follows oldest live request
                check("R4 flush", {28'd0, flush}, {28'd0, exp_flush});
                // R5: store gate
                check("R5 store_en", {31'd0, mem_store_en}, {31'd0, v[2] && win != 2});
                @(posedge clk);
                #1;
                if (win >= 0) begin
                    saved_pc = wp;
                    saved_cause = wc;
                end
                // R6 / R3 / R7
                check(win < 0 ? "R7 epc hold" : "R6 R3 epc", epc, saved_pc);
                check(win < 0 ? "R7 cause hold" : "R6 cause", {28'd0, cause}, {28'd0, saved_cause});
                check("R8 redirect", {31'd0, redirect}, {31'd0, win >= 0});
                if (win >= 0) begin
                    exp_tgt = vm[0] ? BASE + ({28'd0, wc} << 4) : BASE;
                    check("R8 target", redirect_pc, exp_tgt);
                    @(negedge clk);
                    // R9: live requests everywhere during redirect
                    {dec_valid, dec_req, exe_valid, exe_req, mem_valid, mem_req} = 6'b111111;
                    dec_pc = 32'hDEAD_0000; exe_pc = 32'hDEAD_1000; mem_pc = 32'hDEAD_2000;
                    #1;
                    check("R9 taken", {31'd0, exc_taken}, 0);
                    check("R9 flush", {28'd0, flush}, 0);
                    check("R9 store", {31'd0, mem_store_en}, 1);
                    @(posedge clk);
                    #1;
                    check("R9 epc hold", epc, saved_pc);
                    check("R8 single", {31'd0, redirect}, 0);
                end
                @(negedge clk);
                idle_inputs();
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule